// File: doc/BRIEF.md
# Subcode Q-Channel Block Framer

This block gathers the user bit carried by each incoming audio subframe and groups those bits into subcode Q-channel blocks. A block is a fixed run of 1176 subframes; with a 44.1 kHz sample rate, and so two subframes per sample period, blocks complete at 75 Hz. Each subframe is marked by a one-cycle strobe on the system clock. The block does not search the user data for a sync pattern. The block boundary is set by an explicit realign input, and the block then counts strobes from that point.

The first `Q_BITS` user bits of each block are held in a capture register. When the last subframe of a block arrives, the block publishes a snapshot of those bits and of the 8-bit track-number field. Both values stay unchanged for the whole of the following block, so a register interface can read them at leisure. In the same clock the block raises a sync pulse that lasts exactly one subframe. A change flag rises with the sync pulse when the new track number differs from the previous one, and a downstream change detector uses it.

Top module: `qfr_framer`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `q_sync`, `trk_diff`, `q_block` and `q_track` are all zero, and the subframe count restarts at position 0.
- R2: A block is exactly `BLK_LEN` (default 1176) strobes on `sf_valid` counted since reset, realign or the previous block end. `q_sync` rises in the cycle after the clock edge that samples the last strobe, and never at any other time.
- R3: Once `q_sync` is high, it stays high through any number of cycles without a strobe. It falls after the next strobe is sampled, so the pulse covers exactly one subframe.
- R4: At each block end, `q_block[i]` becomes the user bit of strobe number i of that block (0-based) for every i below `Q_BITS` (default 96). User bits of later strobes in the block have no effect. `q_block` changes at no other time.
- R5: At each block end, `q_track` takes the user bits of strobes 10 to 17 of the block. Strobe 10 goes to `q_track[7]` (MSB first) and strobe 17 goes to `q_track[0]`. `q_track` is stable at all other times.
- R6: When `start` is high on a clock edge, the count returns to position 0, the partial block is discarded without any sync pulse, and `q_sync` and `trk_diff` go low. A strobe sampled in the same cycle is discarded and does not count as strobe 0. `q_block` and `q_track` are unchanged.
- R7: `trk_diff` is high exactly while `q_sync` is high for a block whose track number differs from the track number of the previous block completed since reset. It is always low for the first block after reset.
- R8: In cycles with neither `sf_valid` nor `start`, `user_bit` has no effect and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sf_valid | input | 1 | One-cycle strobe marking a new subframe |
| user_bit | input | 1 | User bit of the strobed subframe |
| start | input | 1 | Realign: begin a new block at the next strobe |
| q_sync | output | 1 | High for one subframe after a block completes |
| trk_diff | output | 1 | Track number changed versus the previous block (valid with q_sync) |
| q_block | output | Q_BITS | Snapshot of the captured Q bits of the last completed block |
| q_track | output | 8 | Snapshot of the track-number field, MSB first |

## Verification
The hardest case to reach from the ports is a realign that lands on a strobe. Two variants matter: a realign on the strobe that would have closed a block, and a realign while the sync pulse is still waiting for its ending strobe. In both, the counter and the pulse must be dropped together and nothing stale may be published. The stimulus runs complete blocks to build up history, then aims `start` at exact strobe positions, including one on the same edge as a strobe. It also uses a position-only bit pattern, so that consecutive blocks carry the same track number; this exercises the equal case of the change flag next to the differing case from random data.

// File: rtl/qfr_pkg.sv
// Shared definitions for the subcode Q-channel block framer.
package qfr_pkg;

    // Default geometry of one subcode block.
    localparam int QFR_BLK_LEN = 1176;
    localparam int QFR_Q_BITS  = 96;
    localparam int QFR_TRK_LO  = 10;
    localparam int QFR_TRK_W   = 8;

    // Per-cycle event decoded from the strobe and realign inputs.
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,   // no strobe, no realign
        EV_BIT     = 2'd1,   // strobe that is not the last of the block
        EV_LAST    = 2'd2,   // strobe that completes the block
        EV_REALIGN = 2'd3    // realign request (wins over a strobe)
    } qfr_ev_e;

endpackage

// File: rtl/qfr_sf_counter.sv
// Subframe position counter.
// Counts strobes from 0 to BLK_LEN-1 and wraps. It decodes each cycle into
// one event for the rest of the framer. Assumes BLK_LEN >= 2 and that start
// takes priority over a coincident strobe.
module qfr_sf_counter
    import qfr_pkg::*;
#(
    parameter int BLK_LEN = QFR_BLK_LEN,
    parameter int CW      = $clog2(BLK_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sf_valid,
    input  logic          start,
    output logic [CW-1:0] pos,
    output qfr_ev_e       ev
);

    localparam logic [CW-1:0] LAST_POS = CW'(BLK_LEN - 1);

    // Classify the current cycle.
    always_comb begin
        if (start)
            ev = EV_REALIGN;
        else if (sf_valid)
            ev = (pos == LAST_POS) ? EV_LAST : EV_BIT;
        else
            ev = EV_IDLE;
    end

    // Advance or clear the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else begin
            case (ev)
                EV_REALIGN,
                EV_LAST:  pos <= '0;
                EV_BIT:   pos <= pos + 1'b1;
                default:  pos <= pos;
            endcase
        end
    end

endmodule

// File: rtl/qfr_capture.sv
// Q-bit capture register.
// Stores the user bit of strobe i at cell i for i < Q_BITS. cap_full shows
// the stored bits with the present strobe's bit already merged in, so a
// block end can publish all of them in one cycle. The cells clear at block
// end and on realign. Assumes Q_BITS <= BLK_LEN.
module qfr_capture
    import qfr_pkg::*;
#(
    parameter int Q_BITS = QFR_Q_BITS,
    parameter int CW     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  qfr_ev_e           ev,
    input  logic [CW-1:0]     pos,
    input  logic              user_bit,
    output logic [Q_BITS-1:0] cap_full
);

    logic              strobe_now;
    logic [Q_BITS-1:0] cap_r;
    logic [Q_BITS-1:0] wr_hit;

    // A strobe is present in this cycle.
    assign strobe_now = (ev == EV_BIT) || (ev == EV_LAST);

    for (genvar i = 0; i < Q_BITS; i++) begin : g_cell
        // Cell i is written by the strobe at position i.
        assign wr_hit[i]   = strobe_now && (pos == CW'(i));
        assign cap_full[i] = wr_hit[i] ? user_bit : cap_r[i];

        // Hold, load or clear one captured bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cap_r[i] <= 1'b0;
            else if (ev == EV_REALIGN || ev == EV_LAST)
                cap_r[i] <= 1'b0;
            else if (wr_hit[i])
                cap_r[i] <= user_bit;
        end
    end

endmodule

// File: rtl/qfr_block_hold.sv
// Block snapshot and sync generation.
// At block end it latches the captured bits and the track field, and raises
// sync for one subframe. It compares the new track number with the previous
// one. The sync pulse and the change flag clear on the next strobe or on a
// realign. Assumes TRK_LO + TRK_W <= Q_BITS.
module qfr_block_hold
    import qfr_pkg::*;
#(
    parameter int Q_BITS = QFR_Q_BITS,
    parameter int TRK_LO = QFR_TRK_LO,
    parameter int TRK_W  = QFR_TRK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  qfr_ev_e           ev,
    input  logic [Q_BITS-1:0] cap_full,
    output logic              q_sync,
    output logic              trk_diff,
    output logic [Q_BITS-1:0] q_block,
    output logic [TRK_W-1:0]  q_track
);

    logic [TRK_W-1:0] trk_now;
    logic             have_prev;

    // Track field, first received bit in the MSB.
    for (genvar k = 0; k < TRK_W; k++) begin : g_trk
        assign trk_now[TRK_W-1-k] = cap_full[TRK_LO+k];
    end

    // Publish the snapshot at block end only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_block   <= '0;
            q_track   <= '0;
            have_prev <= 1'b0;
        end else if (ev == EV_LAST) begin
            q_block   <= cap_full;
            q_track   <= trk_now;
            have_prev <= 1'b1;
        end
    end

    // One-subframe sync pulse and the track-change flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sync   <= 1'b0;
            trk_diff <= 1'b0;
        end else begin
            case (ev)
                EV_LAST: begin
                    q_sync   <= 1'b1;
                    trk_diff <= have_prev && (trk_now != q_track);
                end
                EV_BIT,
                EV_REALIGN: begin
                    q_sync   <= 1'b0;
                    trk_diff <= 1'b0;
                end
                default: begin
                    q_sync   <= q_sync;
                    trk_diff <= trk_diff;
                end
            endcase
        end
    end

endmodule

// File: rtl/qfr_framer.sv
// Subcode Q-channel block framer, top level.
// Groups per-subframe user bits into blocks of BLK_LEN subframes, aligned by
// start. It publishes the first Q_BITS bits and the track field at each block
// end, with a one-subframe sync pulse. Assumes one-cycle sf_valid strobes and
// a synchronous active-low reset.
module qfr_framer
    import qfr_pkg::*;
#(
    parameter int BLK_LEN = QFR_BLK_LEN,
    parameter int Q_BITS  = QFR_Q_BITS,
    parameter int TRK_LO  = QFR_TRK_LO,
    parameter int TRK_W   = QFR_TRK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_valid,
    input  logic              user_bit,
    input  logic              start,
    output logic              q_sync,
    output logic              trk_diff,
    output logic [Q_BITS-1:0] q_block,
    output logic [TRK_W-1:0]  q_track
);

    localparam int CW = $clog2(BLK_LEN);

    qfr_ev_e           ev;
    logic [CW-1:0]     pos;
    logic [Q_BITS-1:0] cap_full;

    qfr_sf_counter #(.BLK_LEN(BLK_LEN), .CW(CW)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sf_valid (sf_valid),
        .start    (start),
        .pos      (pos),
        .ev       (ev)
    );

    qfr_capture #(.Q_BITS(Q_BITS), .CW(CW)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .pos      (pos),
        .user_bit (user_bit),
        .cap_full (cap_full)
    );

    qfr_block_hold #(.Q_BITS(Q_BITS), .TRK_LO(TRK_LO), .TRK_W(TRK_W)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .cap_full (cap_full),
        .q_sync   (q_sync),
        .trk_diff (trk_diff),
        .q_block  (q_block),
        .q_track  (q_track)
    );

endmodule

// File: rtl/qfr_framer_chk.sv
// Property checker for qfr_framer, bound to every instance.
// Keeps its own strobe count to check block length without deep $past.
module qfr_framer_chk #(
    parameter int BLK_LEN = 1176,
    parameter int Q_BITS  = 96,
    parameter int TRK_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sf_valid,
    input logic              start,
    input logic              q_sync,
    input logic              trk_diff,
    input logic [Q_BITS-1:0] q_block,
    input logic [TRK_W-1:0]  q_track
);

    localparam int CW = $clog2(BLK_LEN);
    logic [CW-1:0] seen;

    // Independent count of strobes within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            seen <= '0;
        else if (sf_valid)
            seen <= (seen == CW'(BLK_LEN - 1)) ? '0 : seen + 1'b1;
    end

    // R2
    sync_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_sync) |-> $past(sf_valid && !start && seen == CW'(BLK_LEN - 1)));

    // R2
    sync_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && !start && seen == CW'(BLK_LEN - 1)) |=> q_sync);

    // R3
    sync_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sync && !sf_valid && !start) |=> q_sync);

    // R3
    sync_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sync && sf_valid) |=> !q_sync);

    // R4
    block_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(q_sync) |-> $stable(q_block));

    // R5
    track_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(q_sync) |-> $stable(q_track));

    // R6
    realign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!q_sync && !trk_diff));

    // R7
    diff_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_diff |-> q_sync);

endmodule

bind qfr_framer qfr_framer_chk #(
    .BLK_LEN (BLK_LEN),
    .Q_BITS  (Q_BITS),
    .TRK_W   (TRK_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sf_valid (sf_valid),
    .start    (start),
    .q_sync   (q_sync),
    .trk_diff (trk_diff),
    .q_block  (q_block),
    .q_track  (q_track)
);

// File: tb/qfr_framer_tb.sv
// Bench for qfr_framer: a behavioural reference model compared every cycle.
module qfr_framer_tb_top;

    localparam int BLK = 1176;
    localparam int QB  = 96;
    localparam int TW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sf_valid = 1'b0;
    logic          user_bit = 1'b0;
    logic          start = 1'b0;
    logic          q_sync;
    logic          trk_diff;
    logic [QB-1:0] q_block;
    logic [TW-1:0] q_track;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    qfr_framer dut_i (
        .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .user_bit(user_bit),
        .start(start), .q_sync(q_sync), .trk_diff(trk_diff),
        .q_block(q_block), .q_track(q_track)
    );

    // Reference model state
    int            m_pos = 0;
    bit            m_bits[$];
    logic          m_sync = 0, m_diff = 0, m_have = 0;
    logic [QB-1:0] m_block = '0;
    logic [TW-1:0] m_track = '0;
    logic          last_start = 0, last_valid = 0;

    always @(posedge clk) begin
        last_start = start;
        last_valid = sf_valid;
        if (!rst_n) begin
            m_pos = 0; m_bits.delete(); m_sync = 0; m_diff = 0; m_have = 0;
            m_block = '0; m_track = '0;
        end else if (start) begin
            m_pos = 0; m_bits.delete(); m_sync = 0; m_diff = 0;
        end else if (sf_valid) begin
            m_sync = 0; m_diff = 0;
            if (m_bits.size() < QB) m_bits.push_back(user_bit);
            m_pos++;
            if (m_pos == BLK) begin
                logic [TW-1:0] t;
                for (int i = 0; i < QB; i++) m_block[i] = m_bits[i];
                for (int k = 0; k < TW; k++) t[TW-1-k] = m_bits[10+k];
                m_diff  = m_have && (t != m_track);
                m_track = t;
                m_have  = 1;
                m_sync  = 1;
                m_pos   = 0;
                m_bits.delete();
            end
        end
    end

    task automatic check1(input string req, input logic [QB-1:0] act, input logic [QB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison; the tag names the stimulus of the previous edge.
    task automatic compare();
        string ctx;
        ctx = last_start ? "R6" : (!last_valid ? "R8" : "");
        check1({ctx, " R2/R3 q_sync"}, QB'(q_sync), QB'(m_sync));
        check1({ctx, " R7 trk_diff"}, QB'(trk_diff), QB'(m_diff));
        check1({ctx, " R4 q_block"}, q_block, m_block);
        check1({ctx, " R5 q_track"}, QB'(q_track), QB'(m_track));
    endtask

    task automatic tick(input logic v, input logic b, input logic s);
        @(negedge clk);
        compare();
        sf_valid = v; user_bit = b; start = s;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // mode 0: random bits; mode 1: bits depend on position only
    task automatic strobes(input int n, input int mode, input int maxgap);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (mode == 0) ? next_rand() : logic'(((m_pos * 7) % 3) == 0);
            tick(1'b1, b, 1'b0);
            if (maxgap > 0)
                for (int g = 0; g < (i % (maxgap + 1)); g++) tick(1'b0, next_rand(), 1'b0);
        end
    endtask

    initial begin
        repeat (4) tick(1'b0, 1'b0, 1'b0);
        // R1: reset state
        check1("R1 q_sync", QB'(q_sync), '0);
        check1("R1 trk_diff", QB'(trk_diff), '0);
        check1("R1 q_block", q_block, '0);
        check1("R1 q_track", QB'(q_track), '0);
        @(negedge clk); rst_n = 1'b1;
        tick(1'b0, 1'b1, 1'b0);
        check1("R1 after release", QB'({q_sync, trk_diff}), '0);

        strobes(2 * BLK, 0, 0);        // R2 back-to-back random
        strobes(2 * BLK, 1, 3);        // R7 equal tracks, gaps (R3, R8)
        strobes(600, 0, 2);
        tick(1'b0, 1'b0, 1'b1);        // R6 realign mid-block
        strobes(BLK, 1, 1);
        repeat (3) tick(1'b0, 1'b1, 1'b0);
        check1("R3 sync held across idle", QB'(q_sync), QB'(1));
        tick(1'b0, 1'b0, 1'b1);        // R6 realign during sync
        tick(1'b0, 1'b0, 1'b0);
        check1("R6 sync dropped", QB'(q_sync), '0);
        strobes(BLK - 1, 0, 0);
        tick(1'b1, 1'b1, 1'b1);        // R6 realign on the closing strobe
        tick(1'b0, 1'b0, 1'b0);
        check1("R6 no sync on coincident strobe", QB'(q_sync), '0);
        strobes(BLK, 0, 2);
        strobes(BLK + 5, 1, 0);
        repeat (3) tick(1'b0, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule